// File: doc/BRIEF.md
# Direct Master Abort Handler

This block sits on the direct master path of a bridge that carries local bus cycles onto a host bus. It has three abort strobes from the host bus side: the addressed target did not respond, the target refused the transfer, and an external retry counter ran out. A strobe counts only while a direct master transfer is active. Each abort kind sets its own sticky status bit. A local system-error output is driven from those bits through a two-bit enable field.

The block also ends the local master's stalled cycle. When an abort hits a master that is waiting, the block returns ready together with burst-terminate for a single cycle. When the master is not yet waiting, the pair is held and delivered on the first cycle it waits. A burst gets the pair on its first terminated beat only, and later beats of that burst get nothing.

While any status bit is set, new direct master requests are held off. Software frees the path again by writing ones to the status bits. A synchronous local reset input clears all abort state, so a local master stuck in a burst can be recovered.

Top module: `dm_abort_ctrl`

## Requirements
- R1: An abort is a high `mabort_i`, `tabort_i` or `rtimeout_i` while `xfer_i` is high. It sets status bit 0, 1 or 2 of `stat_o` respectively after the next clock edge. Strobes while `xfer_i` is low change nothing.
- R2: A status bit stays set until a cycle with `clr_we_i` high and a 1 at that bit position of `clr_data_i`. Writing 0 leaves the bit unchanged. If a clear and a new abort hit the same bit in one cycle, the bit stays set.
- R3: `serr_o` is high exactly when `irq_en_i[0]` is high and bit 0 or bit 1 of `stat_o` is set, or when `irq_en_i[1]` is high and bit 2 is set.
- R4: An abort in a cycle with `wait_i` high makes `rdy_o` and `bterm_o` high for the following cycle only. They stay low in the cycle after that, even if `wait_i` stays high.
- R5: An abort in a cycle with `wait_i` low is held pending. The pair is delivered one cycle after the first later cycle with `wait_i` high. A pending pair is dropped once every status bit has been cleared.
- R6: After the pair is delivered in a cycle with `burst_i` high, no further pair is produced for any abort until `burst_i` has been low for at least one cycle.
- R7: `dm_en_o` is low while any status bit is set. `dm_req_o` follows `dm_req_i` only while `dm_en_o` is high.
- R8: A cycle with `lrst_i` high clears all status bits, any pending pair and the burst hold. It drops `rdy_o` and `bterm_o` after that edge.
- R9: `rdy_o` and `bterm_o` are always equal, and `rdy_o` is high only if `wait_i` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrst_i | input | 1 | Synchronous local reset of all abort state |
| mabort_i | input | 1 | No-response abort strobe |
| tabort_i | input | 1 | Target-refused abort strobe |
| rtimeout_i | input | 1 | Retry limit reached strobe |
| xfer_i | input | 1 | Direct master transfer active |
| wait_i | input | 1 | Local master waiting for ready |
| burst_i | input | 1 | Local cycle is a burst |
| irq_en_i | input | 2 | Error output enables: bit 0 for the two abort bits, bit 1 for the retry bit |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 3 | Write-one-to-clear mask, same bit order as stat_o |
| dm_req_i | input | 1 | New direct master request from the local side |
| stat_o | output | 3 | Sticky status: bit 0 no-response, bit 1 refused, bit 2 retry limit |
| serr_o | output | 1 | Local system-error output |
| rdy_o | output | 1 | Terminating ready to the local master |
| bterm_o | output | 1 | Burst terminate, paired with rdy_o |
| dm_en_o | output | 1 | Direct master path enabled |
| dm_req_o | output | 1 | Request forwarded to the host bus side |

## Verification
Status bits, the ready/terminate pair and the hold state are registered once, so every one of them is due one clock edge after the cycle that caused it. `serr_o`, `dm_en_o` and `dm_req_o` are combinational from those registers and from the current inputs, so they show up in that same sampled cycle. The driver sets one input pattern per cycle at the falling edge and queues the outcome due after the next rising edge. The monitor pops one entry per cycle a quarter period after that rising edge, so each check lands in exactly the cycle its requirement names. Pending and held cases need several queued cycles each, covering delivery, suppression and the clear or reset that ends them.

// File: rtl/dm_abort_pkg.sv
package dm_abort_pkg;
  localparam int unsigned NSRC = 3;
  localparam int unsigned NGRP = 2;
  localparam int unsigned SRC_MA  = 0;
  localparam int unsigned SRC_TA  = 1;
  localparam int unsigned SRC_RTO = 2;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [NGRP-1:0] grp_vec_t;

  // enable group for each abort source
  function automatic int unsigned src_grp(input int unsigned idx);
    return (idx == SRC_RTO) ? 1 : 0;
  endfunction
endpackage

// File: rtl/dm_abort_detect.sv
module dm_abort_detect
  import dm_abort_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0] strb_i,
  input  logic         xfer_i,
  output logic [N-1:0] evt_o,
  output logic         any_o
);
  always_comb begin
    evt_o = xfer_i ? strb_i : '0;
    any_o = |evt_o;
  end
endmodule

// File: rtl/dm_abort_status.sv
module dm_abort_status
  import dm_abort_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lrst_i,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] stat_o,
  output logic         any_nxt_o
);
  logic [N-1:0] stat_d, stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (lrst_i)                          stat_d[i] = 1'b0;
      else if (evt_i[i])                   stat_d[i] = 1'b1;  // set wins
      else if (clr_we_i && clr_data_i[i])  stat_d[i] = 1'b0;
      else                                 stat_d[i] = stat_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= stat_d[i];
    end
  end

  assign stat_o    = stat_q;
  assign any_nxt_o = |stat_d;
endmodule

// File: rtl/dm_abort_irq.sv
module dm_abort_irq
  import dm_abort_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter int unsigned G = NGRP
) (
  input  logic [N-1:0] stat_i,
  input  logic [G-1:0] en_i,
  output logic         serr_o
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int unsigned GI = src_grp(i);
    assign hit[i] = stat_i[i] & en_i[GI];
  end

  assign serr_o = |hit;
endmodule

// File: rtl/dm_abort_term.sv
module dm_abort_term (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrst_i,
  input  logic evt_i,
  input  logic any_nxt_i,
  input  logic wait_i,
  input  logic burst_i,
  output logic rdy_o,
  output logic bterm_o
);
  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic deliver;

  assign deliver = (evt_i | pend_q) & wait_i & ~hold_q & ~lrst_i;

  always_comb begin
    // pending pair dies with the last status bit or with a burst hold
    pend_d = (evt_i | pend_q) & ~deliver & ~hold_q & any_nxt_i & ~lrst_i;
    if (lrst_i)                  hold_d = 1'b0;
    else if (deliver && burst_i) hold_d = 1'b1;
    else if (!burst_i)           hold_d = 1'b0;
    else                         hold_d = hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      hold_q  <= 1'b0;
      rdy_o   <= 1'b0;
      bterm_o <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      hold_q  <= hold_d;
      rdy_o   <= deliver;
      bterm_o <= deliver;
    end
  end
endmodule

// File: rtl/dm_abort_ctrl.sv
module dm_abort_ctrl
  import dm_abort_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lrst_i,
  input  logic            mabort_i,
  input  logic            tabort_i,
  input  logic            rtimeout_i,
  input  logic            xfer_i,
  input  logic            wait_i,
  input  logic            burst_i,
  input  logic [NGRP-1:0] irq_en_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_data_i,
  input  logic            dm_req_i,
  output logic [NSRC-1:0] stat_o,
  output logic            serr_o,
  output logic            rdy_o,
  output logic            bterm_o,
  output logic            dm_en_o,
  output logic            dm_req_o
);
  src_vec_t strb, evt;
  logic     evt_any, any_nxt;

  always_comb begin
    strb          = '0;
    strb[SRC_MA]  = mabort_i;
    strb[SRC_TA]  = tabort_i;
    strb[SRC_RTO] = rtimeout_i;
  end

  dm_abort_detect #(.N(NSRC)) i_detect (
    .strb_i (strb),
    .xfer_i (xfer_i),
    .evt_o  (evt),
    .any_o  (evt_any)
  );

  dm_abort_status #(.N(NSRC)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lrst_i     (lrst_i),
    .evt_i      (evt),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .stat_o     (stat_o),
    .any_nxt_o  (any_nxt)
  );

  dm_abort_irq #(.N(NSRC), .G(NGRP)) i_irq (
    .stat_i (stat_o),
    .en_i   (irq_en_i),
    .serr_o (serr_o)
  );

  dm_abort_term i_term (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lrst_i    (lrst_i),
    .evt_i     (evt_any),
    .any_nxt_i (any_nxt),
    .wait_i    (wait_i),
    .burst_i   (burst_i),
    .rdy_o     (rdy_o),
    .bterm_o   (bterm_o)
  );

  assign dm_en_o  = ~|stat_o;
  assign dm_req_o = dm_req_i & dm_en_o;
endmodule

// File: rtl/dm_abort_chk.sv
module dm_abort_chk
  import dm_abort_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lrst_i,
  input logic            mabort_i,
  input logic            tabort_i,
  input logic            rtimeout_i,
  input logic            xfer_i,
  input logic            wait_i,
  input logic            burst_i,
  input logic [NGRP-1:0] irq_en_i,
  input logic            clr_we_i,
  input logic [NSRC-1:0] clr_data_i,
  input logic            dm_req_i,
  input logic [NSRC-1:0] stat_o,
  input logic            serr_o,
  input logic            rdy_o,
  input logic            bterm_o,
  input logic            dm_en_o,
  input logic            dm_req_o
);
  assert_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && mabort_i && !lrst_i) |=> stat_o[SRC_MA]);

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[SRC_TA] && !clr_we_i && !lrst_i) |=> stat_o[SRC_TA]);

  assert_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == '0) |-> !serr_o);

  assert_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o == bterm_o);

  assert_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> $past(wait_i));

  assert_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o != '0) |-> (!dm_en_o && !dm_req_o));

  assert_lrst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_i |=> (stat_o == '0 && !rdy_o));
endmodule

bind dm_abort_ctrl dm_abort_chk i_chk (.*);

// File: tb/test_dm_abort_ctrl.sv
`timescale 1ns/1ps
module test_dm_abort_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lrst_i = 1'b0;
  logic       mabort_i = 1'b0, tabort_i = 1'b0, rtimeout_i = 1'b0;
  logic       xfer_i = 1'b0, wait_i = 1'b0, burst_i = 1'b0;
  logic [1:0] irq_en_i = 2'b11;
  logic       clr_we_i = 1'b0;
  logic [2:0] clr_data_i = 3'b000;
  logic       dm_req_i = 1'b0;
  logic [2:0] stat_o;
  logic       serr_o, rdy_o, bterm_o, dm_en_o, dm_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected item: {rdy, stat[2:0], serr, dm_en, dm_req}
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  dm_abort_ctrl i_dm_abort_ctrl (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, outcome due after the next rising edge
  task automatic step(input logic [1:0] en, input logic [2:0] ev, input logic x,
                      input logic w, input logic b, input logic cw, input logic [2:0] cd,
                      input logic rq, input logic lr, input logic [6:0] exp, input string tag);
    @(negedge clk_i);
    irq_en_i   = en;
    mabort_i   = ev[0];
    tabort_i   = ev[1];
    rtimeout_i = ev[2];
    xfer_i     = x;
    wait_i     = w;
    burst_i    = b;
    clr_we_i   = cw;
    clr_data_i = cd;
    dm_req_i   = rq;
    lrst_i     = lr;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {1'b0, rdy_o, stat_o, serr_o, dm_en_o, dm_req_o}, {1'b0, e});
      chk({t, " bterm_R9"}, {7'b0, bterm_o}, {7'b0, e[6]});
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("reset stat R2", {5'b0, stat_o}, 8'h00);
    chk("reset serr R3", {7'b0, serr_o}, 8'h00);
    chk("reset rdy R4", {6'b0, rdy_o, bterm_o}, 8'h00);
    chk("reset en R7", {7'b0, dm_en_o}, 8'h01);

    // en, ev, x, w, b, cw, cd, rq, lr, exp{rdy,stat,serr,en,req}
    step(2'b11, 3'b001, 1, 1, 0, 0, 3'b000, 1, 0, 7'b1_001_1_0_0, "R1 R4 abort while waiting");
    step(2'b11, 3'b000, 0, 0, 0, 0, 3'b000, 1, 0, 7'b0_001_1_0_0, "R7 request held off");
    step(2'b11, 3'b000, 0, 0, 0, 1, 3'b001, 1, 0, 7'b0_000_0_1_1, "R2 R7 clear re-enables");
    step(2'b11, 3'b010, 1, 1, 1, 0, 3'b000, 0, 0, 7'b1_010_1_0_0, "R6 burst first beat");
    step(2'b11, 3'b100, 1, 1, 1, 0, 3'b000, 0, 0, 7'b0_110_1_0_0, "R6 later abort in burst");
    step(2'b11, 3'b000, 1, 1, 1, 0, 3'b000, 0, 0, 7'b0_110_1_0_0, "R6 later beat no ready");
    step(2'b11, 3'b000, 0, 0, 0, 0, 3'b000, 0, 0, 7'b0_110_1_0_0, "R2 bits sticky");
    step(2'b11, 3'b000, 0, 0, 0, 1, 3'b010, 0, 0, 7'b0_100_1_0_0, "R2 partial clear");
    step(2'b11, 3'b000, 0, 0, 0, 1, 3'b100, 0, 0, 7'b0_000_0_1_0, "R2 clear retry bit");
    step(2'b11, 3'b001, 1, 0, 0, 0, 3'b000, 0, 0, 7'b0_001_1_0_0, "R5 abort not waiting");
    step(2'b11, 3'b000, 1, 1, 0, 0, 3'b000, 0, 0, 7'b1_001_1_0_0, "R5 pending delivered");
    step(2'b11, 3'b000, 1, 1, 0, 0, 3'b000, 0, 0, 7'b0_001_1_0_0, "R4 single cycle");
    step(2'b11, 3'b000, 0, 0, 0, 1, 3'b001, 0, 0, 7'b0_000_0_1_0, "R2 clear");
    step(2'b11, 3'b111, 0, 1, 0, 0, 3'b000, 0, 0, 7'b0_000_0_1_0, "R1 strobes without transfer");
    step(2'b01, 3'b100, 1, 0, 0, 0, 3'b000, 0, 0, 7'b0_100_0_0_0, "R3 retry masked");
    step(2'b01, 3'b000, 0, 0, 0, 1, 3'b100, 0, 0, 7'b0_000_0_1_0, "R2 clear retry");
    step(2'b01, 3'b000, 1, 1, 0, 0, 3'b000, 0, 0, 7'b0_000_0_1_0, "R5 pending dropped by clear");
    step(2'b10, 3'b001, 1, 0, 0, 0, 3'b000, 0, 0, 7'b0_001_0_0_0, "R3 abort masked");
    step(2'b10, 3'b100, 1, 0, 0, 0, 3'b000, 0, 0, 7'b0_101_1_0_0, "R3 retry enabled");
    step(2'b10, 3'b000, 0, 0, 0, 1, 3'b000, 0, 0, 7'b0_101_1_0_0, "R2 zero write no effect");
    step(2'b10, 3'b000, 1, 1, 0, 0, 3'b000, 0, 0, 7'b1_101_1_0_0, "R5 pending survives zero write");
    step(2'b10, 3'b000, 0, 0, 0, 1, 3'b101, 0, 0, 7'b0_000_0_1_0, "R2 clear both");
    step(2'b11, 3'b001, 1, 0, 0, 1, 3'b001, 0, 0, 7'b0_001_1_0_0, "R2 set wins over clear");
    step(2'b11, 3'b000, 1, 1, 0, 0, 3'b000, 0, 0, 7'b1_001_1_0_0, "R5 pending after set-wins");
    step(2'b11, 3'b010, 1, 1, 1, 0, 3'b000, 0, 0, 7'b1_011_1_0_0, "R6 burst terminated");
    step(2'b11, 3'b000, 1, 1, 1, 0, 3'b000, 0, 1, 7'b0_000_0_1_0, "R8 local reset");
    step(2'b11, 3'b001, 1, 1, 1, 0, 3'b000, 0, 0, 7'b1_001_1_0_0, "R8 hold cleared by reset");
    step(2'b11, 3'b000, 0, 0, 0, 0, 3'b000, 1, 1, 7'b0_000_0_1_1, "R7 R8 request passes");
    step(2'b11, 3'b000, 0, 0, 0, 0, 3'b000, 1, 0, 7'b0_000_0_1_1, "R7 idle");

    @(negedge clk_i);
    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule